// File: doc/BRIEF.md
# Clock Prescaler Bank with Priority Ratio Select

The block holds several independent clock dividers (three by default). Each has its own source clock and its own divided output. Software picks each divider's ratio by writing a 32-bit control word through a small synchronous register port. The port runs on the bus clock, and every word can be read back.

The low seven bits of a control word are ratio flags. When no flag is set, the source clock passes straight through. When more than one flag is set, the flag with the lowest bit number decides the ratio. The control word crosses into the divider's clock domain through a stage synchronizer with a stability filter. The divider adopts a new ratio only when its current output period ends, so a reprogram never produces a short pulse.

Top module: `clk_prescaler_bank`

## Requirements
- R1: After `rst_n` is released, every control word reads 0 and every `div_clk` follows its `src_clk`.
- R2: A write stores bits 6:0 of `reg_wdata`. A read of the same channel returns them, and bits 31:7 read as 0.
- R3: Channel k's control word sits at byte address 0x54 + 4*k. A read of any other address returns 0, and a write to any other address changes no control word.
- R4: When all seven flags of a channel are 0, that channel's `div_clk` equals its `src_clk`.
- R5: A single flag selects the output period in source cycles: bit 0 gives 2, bit 1 gives 3, bit 2 gives 4, bit 3 gives 5, bit 4 gives 6, bit 5 gives 8 and bit 6 gives 16.
- R6: For a ratio N, the output is high for floor(N/2) source cycles and low for the remaining cycles. Even ratios therefore give a 50% duty cycle, and odd ratios have a high phase one cycle shorter than the low phase.
- R7: When several flags are set, only the lowest-numbered set flag decides the ratio.
- R8: A new ratio takes effect only after the current output period completes. Every high or low phase seen across the change has the length of either the old ratio or the new one.
- R9: Each channel divides its own source clock by its own ratio, independently of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| reg_we | input | 1 | Write strobe, sampled on `bus_clk` |
| reg_addr | input | ADDR_W (8) | Byte address of the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_clk | input | NUM_CH (3) | Source clock of each channel |
| div_clk | output | NUM_CH (3) | Divided or passed-through clock of each channel |

## Verification
The assertions assume that each control word stays unchanged for several source-clock cycles after a write. This lets the stability filter hand exactly one clean word to the divider. The stimulus meets this assumption by writing at most one word per settling window, then waiting tens of source cycles before it measures. The high-time and ratio-hold properties also assume that `rst_n` is held for a few cycles of every clock. The bench releases reset only after all three source clocks have run.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
   localparam int FLAG_W  = 7;
   localparam int RATIO_W = 5;
   localparam int DATA_W  = 32;

   // ratio chosen by each flag position
   function automatic logic [RATIO_W-1:0] ratio_of_flag(input int idx);
      case (idx)
         0:       return RATIO_W'(2);
         1:       return RATIO_W'(3);
         2:       return RATIO_W'(4);
         3:       return RATIO_W'(5);
         4:       return RATIO_W'(6);
         5:       return RATIO_W'(8);
         default: return RATIO_W'(16);
      endcase
   endfunction
endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
   import clkpre_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int ADDR_W   = 8,
   parameter int BASE_OFS = 'h54,
   parameter int STRIDE   = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [DATA_W-1:0]              wdata_i,
   output logic [DATA_W-1:0]              rdata_o,
   output logic [NUM_CH-1:0][FLAG_W-1:0]  ctrl_o
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << FLAG_W) - 1);

   logic [NUM_CH-1:0]             hit;
   logic [NUM_CH-1:0][FLAG_W-1:0] ctrl_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = (addr_i == ADDR_W'(BASE_OFS + c * STRIDE));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              ctrl_q[c] <= '0;
         else if (we_i && hit[c]) ctrl_q[c] <= wdata_i[FLAG_W-1:0];
      end

      // R2: stored word equals masked write data
      assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (we_i && hit[c]) |=> ({{(DATA_W-FLAG_W){1'b0}}, ctrl_q[c]} == ($past(wdata_i) & MASK)))
         else $error("write not stored");
   end

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (hit[c]) rdata_o = {{(DATA_W-FLAG_W){1'b0}}, ctrl_q[c]};
   end

   assign ctrl_o = ctrl_q;

   // R3: writes outside the window touch nothing
   assert_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit == '0) |=> $stable(ctrl_q))
      else $error("stray write changed a control word");
endmodule

// File: rtl/clkpre_sel.sv
module clkpre_sel
   import clkpre_pkg::*;
(
   input  logic [FLAG_W-1:0]  flags_i,
   output logic [RATIO_W-1:0] ratio_o
);
   logic [FLAG_W-1:0] pick;

   // scan from the top down so the lowest set flag is assigned last
   always_comb begin
      pick    = '0;
      ratio_o = '0;
      for (int i = FLAG_W - 1; i >= 0; i--) begin
         if (flags_i[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
            ratio_o = ratio_of_flag(i);
         end
      end
   end

   always_comb begin
      if (!$isunknown(flags_i)) begin
         assert_pick_onehot_R7: assert ($onehot0(pick)) else $error("pick not one-hot");
         assert_lowest_wins_R7: assert (((pick & ~flags_i) == '0) &&
                                        (((pick - 1'b1) & flags_i) == '0))
            else $error("pick is not the lowest set flag");
         assert_zero_passes_R4: assert ((flags_i == '0) == (ratio_o == '0))
            else $error("bypass decode mismatch");
      end
   end
endmodule

// File: rtl/clkpre_div.sv
module clkpre_div
   import clkpre_pkg::*;
#(
   parameter bit USE_SYNC = 1'b1
) (
   input  logic              src_clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] ctrl_i,
   output logic              div_clk
);
   logic [FLAG_W-1:0]  ctrl_ok;
   logic [RATIO_W-1:0] ratio_new, ratio_q, cnt_q, hi_run;
   logic               div_q, bypass, at_end;

   if (USE_SYNC) begin : g_sync
      logic [FLAG_W-1:0] s1, s2, s3, held;
      always_ff @(posedge src_clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= '0; s2 <= '0; s3 <= '0; held <= '0;
         end else begin
            s1 <= ctrl_i;
            s2 <= s1;
            s3 <= s2;
            if (s2 == s3) held <= s3;   // accept only a settled word
         end
      end
      assign ctrl_ok = held;
   end else begin : g_direct
      assign ctrl_ok = ctrl_i;
   end

   clkpre_sel i_sel (.flags_i(ctrl_ok), .ratio_o(ratio_new));

   assign bypass = (ratio_q == '0);
   assign at_end = bypass || (cnt_q == ratio_q - 1'b1);

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         cnt_q   <= '0;
         div_q   <= 1'b1;
      end else if (at_end) begin
         ratio_q <= ratio_new;
         cnt_q   <= '0;
         div_q   <= 1'b1;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
         div_q   <= ((cnt_q + 1'b1) < (ratio_q >> 1));
      end
   end

   // changes happen on a rising source edge while both inputs are high
   assign div_clk = bypass ? src_clk : div_q;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)                hi_run <= '0;
      else if (div_q && !bypass) hi_run <= hi_run + 1'b1;
      else                       hi_run <= '0;
   end

   assert_ratio_hold_R8: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!bypass && !at_end) |=> $stable(ratio_q))
      else $error("ratio changed inside a period");

   assert_high_time_R6: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!bypass && $fell(div_q)) |-> (hi_run == (ratio_q >> 1)))
      else $error("high phase length wrong");
endmodule

// File: rtl/clk_prescaler_bank.sv
module clk_prescaler_bank
   import clkpre_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int ADDR_W   = 8,
   parameter int BASE_OFS = 'h54,
   parameter int STRIDE   = 4,
   parameter bit USE_SYNC = 1'b1
) (
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] src_clk,
   output logic [NUM_CH-1:0] div_clk
);
   localparam int LAST_OFS = BASE_OFS + (NUM_CH - 1) * STRIDE;

   if (NUM_CH < 1)                 begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
   if ((BASE_OFS % 4) != 0)        begin : g_bad_base $error("BASE_OFS must be word aligned"); end
   if (STRIDE < 4 || STRIDE % 4)   begin : g_bad_str  $error("STRIDE must be a word multiple"); end
   if (LAST_OFS >= (1 << ADDR_W))  begin : g_bad_addr $error("register window exceeds ADDR_W"); end

   logic [NUM_CH-1:0][FLAG_W-1:0] ctrl;

   clkpre_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS), .STRIDE(STRIDE)
   ) i_regs (
      .clk(bus_clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .ctrl_o(ctrl)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_div
      clkpre_div #(.USE_SYNC(USE_SYNC)) i_div (
         .src_clk(src_clk[c]), .rst_n(rst_n), .ctrl_i(ctrl[c]), .div_clk(div_clk[c])
      );
   end
endmodule

// File: tb/test_clk_prescaler_bank.sv
`timescale 1ns/1ps
module test_clk_prescaler_bank;
   logic        bus_clk = 0;
   logic        rst_n = 0;
   logic        reg_we = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic [2:0]  src_clk = 0;
   logic [2:0]  div_clk;
   int n_checks = 0;
   int n_err = 0;

   always #2.5 bus_clk = ~bus_clk;   // 200 MHz
   always #3   src_clk[0] = ~src_clk[0];
   always #4   src_clk[1] = ~src_clk[1];
   always #5   src_clk[2] = ~src_clk[2];

   clk_prescaler_bank i_clk_prescaler_bank (
      .bus_clk(bus_clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clk(src_clk), .div_clk(div_clk)
   );

   function automatic int ratio_for_bit(input int b);
      case (b) 0: return 2; 1: return 3; 2: return 4; 3: return 5;
               4: return 6; 5: return 8; default: return 16; endcase
   endfunction

   function automatic logic [7:0] ch_addr(input int ch);
      return 8'(8'h54 + 4 * ch);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge bus_clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge bus_clk); reg_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge bus_clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_pos(input int ch);
      case (ch) 0: @(posedge src_clk[0]); 1: @(posedge src_clk[1]); default: @(posedge src_clk[2]); endcase
   endtask

   task automatic wait_neg(input int ch);
      case (ch) 0: @(negedge src_clk[0]); 1: @(negedge src_clk[1]); default: @(negedge src_clk[2]); endcase
   endtask

   task automatic sample(input int ch, output logic v);
      wait_pos(ch); #1; v = div_clk[ch];
   endtask

   task automatic settle(input int ch);
      repeat (48) wait_pos(ch);
   endtask

   // one full high run and the low run that follows, in source cycles
   task automatic measure(input int ch, output int hi, output int lo);
      logic v;
      hi = -1; lo = -1;
      for (int k = 0; k < 64; k++) begin sample(ch, v); if (v == 0) break; end
      for (int k = 0; k < 64; k++) begin sample(ch, v); if (v == 1) break; end
      if (v != 1) return;
      hi = 1;
      for (int k = 0; k < 64; k++) begin sample(ch, v); if (v) hi++; else break; end
      lo = 1;
      for (int k = 0; k < 64; k++) begin sample(ch, v); if (!v) lo++; else break; end
   endtask

   task automatic check_ratio(input int ch, input int n, input string req);
      int hi, lo;
      measure(ch, hi, lo);
      check(hi + lo == n, {req, " period"}, hi + lo, n);
      check(hi == n / 2, {req, " high time"}, hi, n / 2);
   endtask

   task automatic check_bypass(input int ch, input string req);
      bit ok = 1;
      repeat (5) begin
         wait_pos(ch); #1; if (div_clk[ch] !== 1'b1) ok = 0;
         wait_neg(ch); #1; if (div_clk[ch] !== 1'b0) ok = 0;
      end
      check(ok, {req, " output follows source"}, ok, 1);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int c = 0; c < 3; c++) begin
         rd(ch_addr(c), d);
         check(d == 0, "R1 reset control word", d, 0);
         check_bypass(c, "R1");
      end
   endtask

   task automatic t_readback;
      logic [31:0] d;
      wr(ch_addr(1), 32'hFFFF_FFA5);
      rd(ch_addr(1), d);
      check(d == 32'h25, "R2 readback masks reserved bits", d, 32'h25);
      wr(ch_addr(2), 32'h0000_0040);
      rd(ch_addr(2), d);
      check(d == 32'h40, "R2 readback", d, 32'h40);
      wr(ch_addr(1), 0); wr(ch_addr(2), 0);
   endtask

   task automatic t_decode;
      logic [31:0] d;
      wr(8'h50, 32'h7F); wr(8'h60, 32'h7F); wr(8'h56, 32'h7F);
      rd(8'h50, d); check(d == 0, "R3 read below window", d, 0);
      rd(8'h60, d); check(d == 0, "R3 read above window", d, 0);
      rd(8'h56, d); check(d == 0, "R3 read misaligned", d, 0);
      for (int c = 0; c < 3; c++) begin
         rd(ch_addr(c), d);
         check(d == 0, "R3 stray write left channel unchanged", d, 0);
      end
      settle(0);
      check_bypass(0, "R3");
   endtask

   task automatic t_single;
      for (int b = 0; b < 7; b++) begin
         wr(ch_addr(0), 32'(1 << b));
         settle(0);
         check_ratio(0, ratio_for_bit(b), "R5 R6 single flag");
      end
   endtask

   task automatic t_multi;
      wr(ch_addr(0), 32'h60); settle(0); check_ratio(0, 8, "R7 flags 6,5");
      wr(ch_addr(0), 32'h7F); settle(0); check_ratio(0, 2, "R7 all flags");
      wr(ch_addr(0), 32'h1C); settle(0); check_ratio(0, 4, "R7 flags 4,3,2");
      wr(ch_addr(0), 32'h48); settle(0); check_ratio(0, 5, "R7 flags 6,3");
      wr(ch_addr(0), 32'h52); settle(0); check_ratio(0, 3, "R7 flags 6,4,1");
   endtask

   task automatic t_change;
      logic v, prev;
      int len, runs, bad, short_runs;
      bit first;
      wr(ch_addr(0), 32'h40); settle(0);
      runs = 0; bad = 0; short_runs = 0; first = 1; len = 0; prev = 0;
      fork
         begin
            for (int k = 0; k < 160; k++) begin
               sample(0, v);
               if (k == 0) begin prev = v; len = 1; end
               else if (v == prev) len++;
               else begin
                  if (!first) begin
                     runs++;
                     if (len != 8 && len != 1) bad++;
                     if (len == 1) short_runs++;
                  end
                  first = 0; prev = v; len = 1;
               end
            end
         end
         begin
            #200;
            wr(ch_addr(0), 32'h01);
         end
      join
      check(bad == 0, "R8 no runt phase across change", bad, 0);
      check(short_runs >= 4, "R8 new ratio reached", short_runs, 4);
   endtask

   task automatic t_indep;
      wr(ch_addr(0), 32'h08); wr(ch_addr(1), 32'h10); wr(ch_addr(2), 32'h02);
      settle(0); settle(1); settle(2);
      check_ratio(0, 5, "R9 channel 0");
      check_ratio(1, 6, "R9 channel 1");
      check_ratio(2, 3, "R9 channel 2");
   endtask

   task automatic t_bypass;
      wr(ch_addr(1), 32'h0); settle(1);
      check_bypass(1, "R4 zero word");
      check_ratio(2, 3, "R9 channel 2 unaffected");
   endtask

   initial begin
      #900us;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #50 rst_n = 1;
      t_reset();
      t_readback();
      t_decode();
      t_single();
      t_multi();
      t_change();
      t_indep();
      t_bypass();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule